// File: doc/BRIEF.md
# Bit-Serial PHY Tuning Write Sequencer

This block drives a 16-bit control word that is shared by up to three PHYs. Each PHY's analog tuning bits are reached one bit at a time. A write places a bit address and a data bit in the word and then pulses the strobe line that belongs to the target PHY. The block turns a multi-bit request into that series of single-bit strobed writes. A request gives a start address, a value, a bit count and a PHY index. The value is sent least-significant bit first, and the address rises by one for each bit.

Every bit passes through four timed phases: address setup, data setup, strobe high and strobe low. Each phase lasts a programmable number of clock cycles. Only one multi-bit write can be in flight, and inputs that arrive while the engine is busy are dropped.

A built-in power-up script issues the standard tuning writes for a chosen PHY:
- calibration enable, which is sent to PHY 0 only;
- transmit amplitude and slew;
- the disconnect threshold, whose value is picked by an input.

When the engine is idle, the whole control word can be loaded directly, so that the bits the sequencer does not own can be set.

Top module: `phy_tune_seq`

## Requirements
- R1: After reset, ctrl_word is 0x0000 and busy, done and err are all 0.
- R2: When the engine is idle and no request or boot start is present, wr_valid loads wr_word into ctrl_word on the next cycle.
- R3: Word layout: bits 15:8 hold the bit address, bit 7 holds the data bit, and the strobe for PHY n is bit 2*n.
- R4: A write of length L to start address A with value V makes L strobe pulses on the target PHY's strobe bit. Pulse i carries address A+i and data V[i], so the least-significant bit goes first.
- R5: For each bit, the address is updated first. The data bit is then driven while the strobe is low, then the strobe goes high, then it goes low. Each phase lasts phase_cycles cycles, and a value of 0 counts as 1. With P cycles per phase, the first strobe goes high 2P cycles after acceptance, stays high for P cycles, and later pulses follow every 4P cycles.
- R6: busy rises on the cycle after acceptance and stays high for exactly 4*P*L cycles. done is high for one cycle, on the cycle in which busy falls.
- R7: While busy is high, req_valid, boot_start and wr_valid have no effect, and no request is queued.
- R8: A request with length 0 raises done for one cycle right after acceptance. It does not assert busy, makes no strobe and leaves the word unchanged.
- R9: A request or boot start whose PHY index is NUM_PHY or higher raises err for one cycle. It does not assert busy or done and leaves the word unchanged.
- R10: During a write, only bits 15:8, bit 7 and the target strobe change. All other bits, including the other PHYs' strobes, keep their values.
- R11: The boot script writes these items as one busy period that ends with a single done:
  - 1 bit of value 1 at address 0x0c, for PHY 0 only;
  - 5 bits of 0x14 at 0x20;
  - 2 bits at 0x2a, whose value is 3 when boot_thr_hi is 1 and 2 when it is 0.
- R12: When the engine is idle, boot_start takes priority over req_valid, and req_valid takes priority over wr_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a multi-bit write |
| req_addr | input | 8 | Start bit address |
| req_data | input | DATA_W | Value to send, LSB first |
| req_len | input | LEN_W | Number of bits |
| req_phy | input | PHY_W | Target PHY index |
| boot_start | input | 1 | Start the power-up script |
| boot_phy | input | PHY_W | PHY index for the script |
| boot_thr_hi | input | 1 | Disconnect threshold: 1 selects 3, 0 selects 2 |
| phase_cycles | input | CNT_W | Cycles per phase, latched at acceptance |
| wr_valid | input | 1 | Load the whole control word |
| wr_word | input | 16 | Word to load |
| ctrl_word | output | 16 | Shared PHY control word |
| busy | output | 1 | Write in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle pulse for a bad PHY index |

## Verification
The assertions assume that phase_cycles only matters at acceptance. They also assume that a length-0 request is not held for two cycles in a row, because that would produce back-to-back done pulses. The stimulus raises each request for exactly one cycle and changes phase_cycles only while the engine is idle. Out-of-range indices are applied only as single-cycle requests, so every err pulse stands alone.

// File: rtl/phy_tune_pkg.sv
package phy_tune_pkg;
  localparam int WORD_W   = 16;
  localparam int ADDR_LSB = 8;
  localparam int ADDR_W   = 8;
  localparam int DATA_BIT = 7;

  typedef enum logic [2:0] {PH_IDLE, PH_ADDR, PH_DATA, PH_HIGH, PH_LOW} phase_e;

  // bits of the word the sequencer must never disturb
  function automatic logic [WORD_W-1:0] keep_mask(input int num_phy);
    logic [WORD_W-1:0] m;
    m = 16'h007F;
    for (int i = 0; i < num_phy; i++) m[2*i] = 1'b0;
    return m;
  endfunction
endpackage

// File: rtl/phy_tune_timer.sv
module phy_tune_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim_eff;

  assign lim_eff = (limit == '0) ? CNT_W'(1) : limit;
  assign expired = !clear && (cnt == lim_eff - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || clear)  cnt <= '0;
    else if (expired)  cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end

  // R5: a phase never runs past its programmed length
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
    !clear |-> (cnt < lim_eff));
endmodule

// File: rtl/phy_tune_script.sv
module phy_tune_script #(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 4
) (
  input  logic [1:0]        idx,
  input  logic              thr_hi,
  output logic [7:0]        addr,
  output logic [DATA_W-1:0] data,
  output logic [LEN_W-1:0]  len
);
  always_comb begin
    unique case (idx)
      2'd0: begin addr = 8'h0c; data = DATA_W'(1);    len = LEN_W'(1); end
      2'd1: begin addr = 8'h20; data = DATA_W'(8'h14); len = LEN_W'(5); end
      default: begin
        addr = 8'h2a;
        data = thr_hi ? DATA_W'(3) : DATA_W'(2);
        len  = LEN_W'(2);
      end
    endcase
  end
endmodule

// File: rtl/phy_tune_seq.sv
module phy_tune_seq
  import phy_tune_pkg::*;
#(
  parameter int NUM_PHY = 3,
  parameter int DATA_W  = 8,
  parameter int CNT_W   = 8,
  parameter int PHY_W   = 2,
  localparam int LEN_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [7:0]        req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [PHY_W-1:0]  req_phy,
  input  logic              boot_start,
  input  logic [PHY_W-1:0]  boot_phy,
  input  logic              boot_thr_hi,
  input  logic [CNT_W-1:0]  phase_cycles,
  input  logic              wr_valid,
  input  logic [15:0]       wr_word,
  output logic [15:0]       ctrl_word,
  output logic              busy,
  output logic              done,
  output logic              err
);
  localparam logic [WORD_W-1:0] KEEP = keep_mask(NUM_PHY);
  localparam logic [1:0]        LAST_ITEM = 2'd2;

  phase_e              st;
  logic [WORD_W-1:0]   ctrl_q;
  logic                busy_q, done_q, err_q;
  logic [DATA_W-1:0]   sh;
  logic [LEN_W-1:0]    rem;
  logic [PHY_W-1:0]    tgt;
  logic [CNT_W-1:0]    lim_q;
  logic                scr_act, thr_q;
  logic [1:0]          scr_idx, scr_sel;
  logic [7:0]          s_addr;
  logic [DATA_W-1:0]   s_data;
  logic [LEN_W-1:0]    s_len;
  logic                expired, idle, boot_bad, req_bad;
  logic [3:0]          stb_pos;

  assign idle     = (st == PH_IDLE);
  assign boot_bad = (32'(boot_phy) >= NUM_PHY);
  assign req_bad  = (32'(req_phy) >= NUM_PHY);
  assign stb_pos  = 4'({tgt, 1'b0});
  assign scr_sel  = idle ? ((boot_phy == '0) ? 2'd0 : 2'd1) : 2'(scr_idx + 2'd1);

  phy_tune_timer #(.CNT_W(CNT_W)) timer_i (
    .clk(clk), .rst(rst), .clear(idle), .limit(lim_q), .expired(expired)
  );

  phy_tune_script #(.DATA_W(DATA_W), .LEN_W(LEN_W)) script_i (
    .idx(scr_sel), .thr_hi(idle ? boot_thr_hi : thr_q),
    .addr(s_addr), .data(s_data), .len(s_len)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= PH_IDLE; ctrl_q <= '0; busy_q <= 1'b0; done_q <= 1'b0; err_q <= 1'b0;
      sh <= '0; rem <= '0; tgt <= '0; lim_q <= '0;
      scr_act <= 1'b0; thr_q <= 1'b0; scr_idx <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (st)
        PH_IDLE: begin
          if (boot_start) begin
            if (boot_bad) err_q <= 1'b1;
            else begin
              tgt <= boot_phy; thr_q <= boot_thr_hi; lim_q <= phase_cycles;
              scr_act <= 1'b1; scr_idx <= scr_sel;
              ctrl_q[ADDR_LSB +: ADDR_W] <= s_addr;
              sh <= s_data; rem <= s_len;
              busy_q <= 1'b1; st <= PH_ADDR;
            end
          end else if (req_valid) begin
            if (req_bad) err_q <= 1'b1;
            else if (req_len == '0) done_q <= 1'b1;
            else begin
              tgt <= req_phy; lim_q <= phase_cycles; scr_act <= 1'b0;
              ctrl_q[ADDR_LSB +: ADDR_W] <= req_addr;
              sh <= req_data; rem <= req_len;
              busy_q <= 1'b1; st <= PH_ADDR;
            end
          end else if (wr_valid) begin
            ctrl_q <= wr_word;
          end
        end
        PH_ADDR: if (expired) begin
          ctrl_q[DATA_BIT] <= sh[0];
          ctrl_q[stb_pos]  <= 1'b0;
          st <= PH_DATA;
        end
        PH_DATA: if (expired) begin
          ctrl_q[stb_pos] <= 1'b1;
          st <= PH_HIGH;
        end
        PH_HIGH: if (expired) begin
          ctrl_q[stb_pos] <= 1'b0;
          st <= PH_LOW;
        end
        PH_LOW: if (expired) begin
          if (rem == LEN_W'(1)) begin
            if (scr_act && scr_idx != LAST_ITEM) begin
              scr_idx <= scr_sel;
              ctrl_q[ADDR_LSB +: ADDR_W] <= s_addr;
              sh <= s_data; rem <= s_len;
              st <= PH_ADDR;
            end else begin
              busy_q <= 1'b0; done_q <= 1'b1; scr_act <= 1'b0;
              st <= PH_IDLE;
            end
          end else begin
            ctrl_q[ADDR_LSB +: ADDR_W] <= ctrl_q[ADDR_LSB +: ADDR_W] + 8'd1;
            sh  <= sh >> 1;
            rem <= rem - 1'b1;
            st  <= PH_ADDR;
          end
        end
        default: st <= PH_IDLE;
      endcase
    end
  end

  assign ctrl_word = ctrl_q;
  assign busy      = busy_q;
  assign done      = done_q;
  assign err       = err_q;

  // R6: completion coincides with the fall of busy
  p_done_on_fall_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> done_q);
  p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !busy_q);
  // R9: a rejected request starts nothing
  p_err_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    err_q |-> (!busy_q && !done_q));
  // R5: address and data hold while the strobe is high
  p_hold_high_r5: assert property (@(posedge clk) disable iff (rst)
    (st == PH_HIGH && $past(st) == PH_HIGH) |-> $stable(ctrl_q[15:7]));
  p_strobe_phase_r5: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (ctrl_q[stb_pos] == (st == PH_HIGH)));
  // R10: unowned bits untouched during a write
  p_keep_bits_r10: assert property (@(posedge clk) disable iff (rst)
    (busy_q && $past(busy_q)) |-> $stable(ctrl_q & KEEP));

  for (genvar n = 0; n < NUM_PHY; n++) begin : g_other
    p_other_stb_r10: assert property (@(posedge clk) disable iff (rst)
      (busy_q && $past(busy_q) && tgt != PHY_W'(n)) |-> $stable(ctrl_q[2*n]));
  end
endmodule

// File: tb/phy_tune_seq_tb.sv
`timescale 1ns/1ps
module phy_tune_seq_tb_top;
  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 0, boot_start = 0, boot_thr_hi = 0, wr_valid = 0;
  logic [7:0] req_addr = 0, req_data = 0, phase_cycles = 0;
  logic [3:0] req_len = 0;
  logic [1:0] req_phy = 0, boot_phy = 0;
  logic [15:0] wr_word = 0, ctrl_word;
  logic busy, done, err;

  always #2 clk = ~clk;

  phy_tune_seq dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_data(req_data), .req_len(req_len), .req_phy(req_phy),
    .boot_start(boot_start), .boot_phy(boot_phy), .boot_thr_hi(boot_thr_hi),
    .phase_cycles(phase_cycles), .wr_valid(wr_valid), .wr_word(wr_word),
    .ctrl_word(ctrl_word), .busy(busy), .done(done), .err(err)
  );

  int total = 0, fails = 0, cyc = 0;
  int cap_n = 0, hi_w = 0, rise_c = 0;
  logic [7:0] cap_a [64];
  logic       cap_d [64];
  int         cap_p [64];
  int         cap_c [64];
  logic [15:0] prev = '0;
  int t0, bcnt;

  always @(posedge clk) cyc <= cyc + 1;

  // strobe monitor: records every rising strobe while busy
  always @(negedge clk) begin
    if (!rst) begin
      for (int p = 0; p < 3; p++) begin
        if (busy && !prev[2*p] && ctrl_word[2*p]) begin
          if (cap_n < 64) begin
            cap_a[cap_n] = ctrl_word[15:8]; cap_d[cap_n] = ctrl_word[7];
            cap_p[cap_n] = p; cap_c[cap_n] = cyc;
          end
          cap_n++; rise_c = cyc;
        end
        if (prev[2*p] && !ctrl_word[2*p] && cap_n == 1) hi_w = cyc - rise_c;
      end
    end
    prev = ctrl_word;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wait_idle();
    bcnt = 0;
    while (busy && bcnt < 10000) begin bcnt++; @(negedge clk); end
  endtask

  task automatic issue_req(input logic [7:0] a, input logic [7:0] d, input int l,
                           input int p, input int pc);
    @(negedge clk);
    cap_n = 0; hi_w = 0;
    req_addr = a; req_data = d; req_len = 4'(l); req_phy = 2'(p);
    phase_cycles = 8'(pc); req_valid = 1;
    @(negedge clk);
    req_valid = 0; t0 = cyc;
    wait_idle();
  endtask

  task automatic issue_boot(input int p, input bit thr, input int pc);
    @(negedge clk);
    cap_n = 0;
    boot_phy = 2'(p); boot_thr_hi = thr; phase_cycles = 8'(pc); boot_start = 1;
    @(negedge clk);
    boot_start = 0;
    wait_idle();
  endtask

  task automatic load_word(input logic [15:0] w);
    @(negedge clk); wr_word = w; wr_valid = 1;
    @(negedge clk); wr_valid = 0;
  endtask

  task automatic exp_cap(input int i, input logic [7:0] a, input bit d, input int p,
                         input string tag);
    chk(cap_a[i] == a, tag, cap_a[i], a);
    chk(cap_d[i] == d, tag, cap_d[i], d);
    chk(cap_p[i] == p, tag, cap_p[i], p);
  endtask

  task automatic t_reset();
    chk(ctrl_word == 16'h0, "R1 word", ctrl_word, 0);
    chk({busy, done, err} == 3'b0, "R1 flags", {busy, done, err}, 0);
  endtask

  task automatic t_load();
    load_word(16'h007A);
    chk(ctrl_word == 16'h007A, "R2 load", ctrl_word, 16'h007A);
  endtask

  task automatic t_basic();
    issue_req(8'h40, 8'hA5, 3, 0, 2);
    chk(cap_n == 3, "R4 count", cap_n, 3);
    exp_cap(0, 8'h40, 1, 0, "R4 bit0");
    exp_cap(1, 8'h41, 0, 0, "R4 bit1");
    exp_cap(2, 8'h42, 1, 0, "R4 bit2");
    chk(cap_c[0] - t0 == 4, "R5 first rise", cap_c[0] - t0, 4);
    chk(cap_c[1] - cap_c[0] == 8, "R5 pacing", cap_c[1] - cap_c[0], 8);
    chk(hi_w == 2, "R5 high width", hi_w, 2);
    chk(bcnt == 24, "R6 busy len", bcnt, 24);
    chk(done == 1, "R6 done rise", done, 1);
    chk(ctrl_word == 16'h42FA, "R3 R10 final word", ctrl_word, 16'h42FA);
    @(negedge clk);
    chk(done == 0, "R6 done pulse", done, 0);
  endtask

  task automatic t_phy2_min_phase();
    load_word(16'h0000);
    issue_req(8'h10, 8'h3C, 8, 2, 0);
    chk(cap_n == 8, "R4 count8", cap_n, 8);
    for (int i = 0; i < 8; i++)
      exp_cap(i, 8'(8'h10 + i), (8'h3C >> i) & 1, 2, "R4 lsb first");
    chk(cap_c[0] - t0 == 2, "R5 zero phase", cap_c[0] - t0, 2);
    chk(bcnt == 32, "R6 busy len8", bcnt, 32);
    chk(ctrl_word == 16'h1700, "R3 final", ctrl_word, 16'h1700);
  endtask

  task automatic t_busy_ignore();
    @(negedge clk);
    cap_n = 0;
    req_addr = 8'h50; req_data = 8'h02; req_len = 4'd2; req_phy = 2'd1;
    phase_cycles = 8'd1; req_valid = 1;
    @(negedge clk); req_valid = 0;
    @(negedge clk);
    req_addr = 8'h99; req_phy = 2'd0; req_valid = 1; wr_word = 16'hFFFF; wr_valid = 1;
    boot_start = 1; boot_phy = 2'd0;
    @(negedge clk);
    req_valid = 0; wr_valid = 0; boot_start = 0;
    wait_idle();
    repeat (4) @(negedge clk);
    chk(busy == 0, "R7 not queued", busy, 0);
    chk(cap_n == 2, "R7 strobe count", cap_n, 2);
    exp_cap(0, 8'h50, 0, 1, "R7 bit0");
    exp_cap(1, 8'h51, 1, 1, "R7 bit1");
    chk(ctrl_word == 16'h5180, "R7 word", ctrl_word, 16'h5180);
  endtask

  task automatic t_len0();
    issue_req(8'h33, 8'hFF, 0, 0, 1);
    chk(done == 1 && busy == 0, "R8 done", {done, busy}, 2);
    chk(cap_n == 0, "R8 no strobe", cap_n, 0);
    chk(ctrl_word == 16'h5180, "R8 word", ctrl_word, 16'h5180);
  endtask

  task automatic t_bad_phy();
    issue_req(8'h33, 8'hFF, 3, 3, 1);
    chk({err, done, busy} == 3'b100, "R9 err", {err, done, busy}, 4);
    chk(ctrl_word == 16'h5180, "R9 word", ctrl_word, 16'h5180);
    @(negedge clk);
    chk(err == 0, "R9 pulse", err, 0);
  endtask

  task automatic t_boot0();
    issue_boot(0, 1'b1, 1);
    chk(cap_n == 8, "R11 count phy0", cap_n, 8);
    exp_cap(0, 8'h0c, 1, 0, "R11 cal");
    for (int i = 0; i < 5; i++)
      exp_cap(1 + i, 8'(8'h20 + i), (8'h14 >> i) & 1, 0, "R11 amp");
    exp_cap(6, 8'h2a, 1, 0, "R11 thr3 b0");
    exp_cap(7, 8'h2b, 1, 0, "R11 thr3 b1");
    chk(bcnt == 32, "R11 busy", bcnt, 32);
    chk(done == 1, "R11 done", done, 1);
  endtask

  task automatic t_boot1();
    issue_boot(1, 1'b0, 1);
    chk(cap_n == 7, "R11 count phy1", cap_n, 7);
    exp_cap(0, 8'h20, 0, 1, "R11 skip cal");
    exp_cap(5, 8'h2a, 0, 1, "R11 thr2 b0");
    exp_cap(6, 8'h2b, 1, 1, "R11 thr2 b1");
    chk(bcnt == 28, "R11 busy phy1", bcnt, 28);
  endtask

  task automatic t_priority();
    @(negedge clk);
    cap_n = 0;
    boot_phy = 2'd2; boot_thr_hi = 1; boot_start = 1; phase_cycles = 8'd1;
    req_addr = 8'h77; req_data = 8'h01; req_len = 4'd1; req_phy = 2'd0; req_valid = 1;
    @(negedge clk);
    boot_start = 0; req_valid = 0;
    wait_idle();
    chk(cap_n == 7, "R12 boot wins", cap_n, 7);
    exp_cap(6, 8'h2b, 1, 2, "R12 boot item");
    @(negedge clk);
    req_addr = 8'h66; req_len = 4'd1; req_phy = 2'd1; req_valid = 1;
    wr_word = 16'h0000; wr_valid = 1;
    @(negedge clk);
    req_valid = 0; wr_valid = 0;
    wait_idle();
    chk(ctrl_word[15:8] == 8'h66, "R12 req over load", ctrl_word[15:8], 8'h66);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_load();
    t_basic();
    t_phy2_min_phase();
    t_busy_ignore();
    t_len0();
    t_bad_phy();
    t_boot0();
    t_boot1();
    t_priority();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule